// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block sits inside a host-to-PCI bridge and turns a configuration request into the values the bridge needs to start a configuration transaction. Each request carries a bus number, an 8-bit device/function field and a register offset. The block returns three values: the address placed on the PCI bus in the address phase, a map control word for the bridge's configuration window, and the host address through which software reaches the target register.

Bus zero is the segment attached directly to the bridge, so it gets a type 0 cycle. The device is selected by one bit set high. For low slot numbers this bit is in the address itself. For high slot numbers it is in the map control word. Any other bus number gets a type 1 cycle, which carries the bus, slot and function fields for a downstream bridge to decode. A field wider than 8 bits of value is rejected with an error pulse, and no address is returned for it.

The request is a single-cycle strobe. The results are registered and appear one clock later, together with either a valid pulse or an error pulse.

Top module: `cfg_addr_gen`

## Requirements
- R1: While `rst_n` is low, `rsp_vld` and `rsp_err` are 0 and `pci_addr`, `map_ctl` and `host_addr` are all zero. Requests are accepted from the third rising edge after `rst_n` goes high.
- R2: A legal request sampled at a rising edge makes `rsp_vld` 1 for exactly the following cycle, with the new results present in that same cycle. Back-to-back requests each produce their own pulse.
- R3: If `req_bus`, `req_devfn` or `req_off` exceeds 255, the following cycle shows `rsp_err` = 1 and `rsp_vld` = 0, and `pci_addr`, `map_ctl` and `host_addr` are all zero.
- R4: In `map_ctl`, bits 3:1 always hold 3'b101 on a valid response. Bit 0 is 0 for bus 0 (type 0, A1:A0 forced to zero) and 1 for any other bus (type 1, A1:A0 passed from the host).
- R5: Bus 0 with slot `devfn[7:3]` ≤ 12: `pci_addr` = (1 << (slot+11)) | (func << 8), where func = `devfn[2:0]`, and `map_ctl` = 0x0000000A.
- R6: Bus 0 with slot > 12: `pci_addr` = func << 8, carrying no select bit, and `map_ctl` = 0x0000000A | (1 << (slot−5)).
- R7: Bus other than 0: `pci_addr` = bus << 16 | slot << 11 | func << 8, and `map_ctl` = 0x0000000B.
- R8: `host_addr` = `WIN_BASE` + `pci_addr` + offset on every valid response, with a default `WIN_BASE` of 0x61000000.
- R9: Cycles without a request leave `pci_addr`, `map_ctl` and `host_addr` unchanged, whatever the request inputs carry, and keep `rsp_vld` and `rsp_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one cycle per request |
| req_bus | input | IN_W | Bus number |
| req_devfn | input | IN_W | Device/function field: slot in bits 7:3, function in bits 2:0 |
| req_off | input | IN_W | Configuration register offset |
| rsp_vld | output | 1 | Result valid pulse |
| rsp_err | output | 1 | Illegal-input pulse, given in place of the valid pulse |
| pci_addr | output | 32 | Address-phase value |
| map_ctl | output | 32 | Window map control word |
| host_addr | output | 32 | Host-side access address |

## Verification
The bench targets several boundaries.

- **Slot 12 and slot 13.** These sit on either side of the split between the address select and the map select. A wrong comparison would put the select bit in the wrong word, or in both.
- **Slot 31.** This reaches map bit 26.
- **Value 256 in each field.** This tests the overflow check on each field in turn. A check that looked at only the low 8 bits would return an address instead of an error pulse.
- **Bus 255.** This probes truncation of the bus field in the type 1 layout.
- **Idle cycles with changed inputs.** These catch result registers that load without a request.
- **Back-to-back requests.** These catch a valid pulse that is stretched or merged.

// File: rtl/cfg_ag_pkg.sv
package cfg_ag_pkg;
  localparam int ADDR_W   = 32;
  localparam int MAP_W    = 32;
  localparam int FLD_W    = 8;
  localparam int SLOT_W   = 5;
  localparam int FUNC_W   = 3;
  localparam logic [2:0] CYC_CFG = 3'b101;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [MAP_W-1:0]  map;
  } cfg_enc_t;
endpackage

// File: rtl/cfg_fld_chk.sv
module cfg_fld_chk #(
  parameter int IN_W    = 12,
  parameter int FLD_MAX = 255
) (
  input  logic [IN_W-1:0] val,
  output logic            ok
);
  always_comb ok = (int'(val) <= FLD_MAX);
endmodule

// File: rtl/cfg_enc.sv
module cfg_enc
  import cfg_ag_pkg::*;
#(
  parameter int SPLIT_SLOT = 12
) (
  input  logic [FLD_W-1:0] bus,
  input  logic [FLD_W-1:0] devfn,
  output cfg_enc_t         enc
);
  localparam int LO_SEL_SHIFT = 11;
  localparam int HI_SEL_SHIFT = 5;

  logic [SLOT_W-1:0] slot;
  logic [FUNC_W-1:0] fn;

  always_comb begin
    slot = devfn[FLD_W-1:FUNC_W];
    fn   = devfn[FUNC_W-1:0];
    enc  = '0;
    if (bus == '0) begin
      enc.addr = ADDR_W'(fn) << 8;
      enc.map  = MAP_W'({CYC_CFG, 1'b0});
      if (int'(slot) > SPLIT_SLOT)
        enc.map = enc.map | (MAP_W'(1) << (int'(slot) - HI_SEL_SHIFT));
      else
        enc.addr = enc.addr | (ADDR_W'(1) << (int'(slot) + LO_SEL_SHIFT));
    end else begin
      enc.addr = ADDR_W'({bus, slot, fn, 8'h00});
      enc.map  = MAP_W'({CYC_CFG, 1'b1});
    end
  end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
  import cfg_ag_pkg::*;
#(
  parameter int          IN_W       = 12,
  parameter int          SPLIT_SLOT = 12,
  parameter logic [31:0] WIN_BASE   = 32'h6100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [IN_W-1:0]   req_bus,
  input  logic [IN_W-1:0]   req_devfn,
  input  logic [IN_W-1:0]   req_off,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [MAP_W-1:0]  map_ctl,
  output logic [ADDR_W-1:0] host_addr
);
  localparam int FLD_MAX = (1 << FLD_W) - 1;
  localparam int N_FLD   = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // field range checks
  logic [IN_W-1:0]  fld [N_FLD];
  logic [N_FLD-1:0] fld_ok;
  assign fld[0] = req_bus;
  assign fld[1] = req_devfn;
  assign fld[2] = req_off;

  for (genvar g = 0; g < N_FLD; g++) begin : g_chk
    cfg_fld_chk #(.IN_W(IN_W), .FLD_MAX(FLD_MAX)) chk_i (
      .val(fld[g]),
      .ok (fld_ok[g])
    );
  end

  cfg_enc_t enc;
  cfg_enc #(.SPLIT_SLOT(SPLIT_SLOT)) enc_i (
    .bus  (req_bus[FLD_W-1:0]),
    .devfn(req_devfn[FLD_W-1:0]),
    .enc  (enc)
  );

  // next-state
  logic              legal, vld_d, err_d;
  logic [ADDR_W-1:0] addr_d, host_d;
  logic [MAP_W-1:0]  map_d;

  always_comb begin
    legal = &fld_ok;
    vld_d = req_vld & legal;
    err_d = req_vld & ~legal;
    if (legal) begin
      addr_d = enc.addr;
      map_d  = enc.map;
      host_d = WIN_BASE + enc.addr + ADDR_W'(req_off[FLD_W-1:0]);
    end else begin
      addr_d = '0;
      map_d  = '0;
      host_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_vld   <= 1'b0;
      rsp_err   <= 1'b0;
      pci_addr  <= '0;
      map_ctl   <= '0;
      host_addr <= '0;
    end else begin
      rsp_vld <= vld_d;
      rsp_err <= err_d;
      if (req_vld) begin
        pci_addr  <= addr_d;
        map_ctl   <= map_d;
        host_addr <= host_d;
      end
    end
  end
endmodule

// File: rtl/cfg_addr_gen_chk.sv
module cfg_addr_gen_chk #(
  parameter int          IN_W     = 12,
  parameter logic [31:0] WIN_BASE = 32'h6100_0000
) (
  input logic            clk,
  input logic            live_n,
  input logic            req_vld,
  input logic [IN_W-1:0] req_bus,
  input logic [IN_W-1:0] req_devfn,
  input logic [IN_W-1:0] req_off,
  input logic            rsp_vld,
  input logic            rsp_err,
  input logic [31:0]     pci_addr,
  input logic [31:0]     map_ctl,
  input logic [31:0]     host_addr
);
  logic bad_in;
  assign bad_in = (int'(req_bus) > 255) || (int'(req_devfn) > 255) || (int'(req_off) > 255);

  // R2
  vld_after_req_chk: assert property (@(posedge clk) disable iff (!live_n)
    (req_vld && !bad_in) |=> (rsp_vld && !rsp_err));

  // R3
  err_zero_out_chk: assert property (@(posedge clk) disable iff (!live_n)
    (req_vld && bad_in) |=> (rsp_err && !rsp_vld && pci_addr == 0 && map_ctl == 0 && host_addr == 0));

  // R3
  vld_err_excl_chk: assert property (@(posedge clk) disable iff (!live_n)
    !(rsp_vld && rsp_err));

  // R4
  cyc_code_chk: assert property (@(posedge clk) disable iff (!live_n)
    rsp_vld |-> (map_ctl[3:1] == 3'b101));

  // R8
  host_sum_chk: assert property (@(posedge clk) disable iff (!live_n)
    rsp_vld |-> (host_addr == WIN_BASE + pci_addr + 32'($past(req_off))));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!live_n)
    !req_vld |=> ($stable(pci_addr) && $stable(map_ctl) && $stable(host_addr) && !rsp_vld && !rsp_err));
endmodule

bind cfg_addr_gen cfg_addr_gen_chk #(.IN_W(IN_W), .WIN_BASE(WIN_BASE)) chk_i (
  .clk      (clk),
  .live_n   (rst_q_n),
  .req_vld  (req_vld),
  .req_bus  (req_bus),
  .req_devfn(req_devfn),
  .req_off  (req_off),
  .rsp_vld  (rsp_vld),
  .rsp_err  (rsp_err),
  .pci_addr (pci_addr),
  .map_ctl  (map_ctl),
  .host_addr(host_addr)
);

// File: tb/cfg_addr_gen_tb_top.sv
module cfg_addr_gen_tb_top;
  localparam int          IN_W = 12;
  localparam logic [31:0] BASE = 32'h6100_0000;
  localparam int          NV   = 11;

  typedef struct packed {
    logic [11:0] bus;
    logic [11:0] devfn;
    logic [11:0] off;
    logic        err;
    logic [31:0] addr;
    logic [31:0] map;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'h000, 12'h000, 12'h000, 1'b0, 32'h0000_0800, 32'h0000_000A}, // R5 slot 0
    '{12'h000, 12'h063, 12'h010, 1'b0, 32'h0080_0300, 32'h0000_000A}, // R5 slot 12
    '{12'h000, 12'h05A, 12'h020, 1'b0, 32'h0040_0200, 32'h0000_000A}, // R5 slot 11
    '{12'h000, 12'h06D, 12'h004, 1'b0, 32'h0000_0500, 32'h0000_010A}, // R6 slot 13
    '{12'h000, 12'h0FF, 12'h0FF, 1'b0, 32'h0000_0700, 32'h0400_000A}, // R6 slot 31
    '{12'h001, 12'h009, 12'h008, 1'b0, 32'h0001_0900, 32'h0000_000B}, // R7
    '{12'h0FF, 12'h0FF, 12'h03C, 1'b0, 32'h00FF_FF00, 32'h0000_000B}, // R7 bus 255
    '{12'h080, 12'h05A, 12'h040, 1'b0, 32'h0080_5A00, 32'h0000_000B}, // R7
    '{12'h100, 12'h000, 12'h000, 1'b1, 32'h0,         32'h0},         // R3 bus
    '{12'h000, 12'h100, 12'h000, 1'b1, 32'h0,         32'h0},         // R3 devfn
    '{12'h002, 12'h000, 12'h100, 1'b1, 32'h0,         32'h0}          // R3 offset
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 1'b0;
  logic [IN_W-1:0] req_bus = '0, req_devfn = '0, req_off = '0;
  logic rsp_vld, rsp_err;
  logic [31:0] pci_addr, map_ctl, host_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_addr_gen #(.IN_W(IN_W), .WIN_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_off(req_off), .rsp_vld(rsp_vld),
    .rsp_err(rsp_err), .pci_addr(pci_addr), .map_ctl(map_ctl),
    .host_addr(host_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check at the negedge after the capturing edge
  task automatic issue(input vec_t v);
    @(negedge clk);
    req_vld = 1'b1; req_bus = v.bus; req_devfn = v.devfn; req_off = v.off;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    logic [31:0] eh;
    eh = v.err ? 32'h0 : BASE + v.addr + 32'(v.off);
    chk({tag, " R2 vld"}, 32'(rsp_vld), 32'(!v.err));
    chk({tag, " R3 err"}, 32'(rsp_err), 32'(v.err));
    chk({tag, " R5/R6/R7 addr"}, pci_addr, v.addr);
    chk({tag, " R4/R6 map"}, map_ctl, v.map);
    chk({tag, " R8 host"}, host_addr, eh);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ha, hm, hh;
    #35;
    // R1 reset state
    chk("R1 vld", 32'(rsp_vld), 0);
    chk("R1 err", 32'(rsp_err), 0);
    chk("R1 addr", pci_addr, 0);
    chk("R1 map", map_ctl, 0);
    chk("R1 host", host_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      check_vec(VECS[i], $sformatf("vec%0d", i));
    end

    // R9: idle cycles with changing inputs hold the last legal result
    issue(VECS[5]);
    ha = pci_addr; hm = map_ctl; hh = host_addr;
    req_bus = 12'h033; req_devfn = 12'h0F1; req_off = 12'h0AA;
    @(negedge clk);
    @(negedge clk);
    chk("R9 vld low", 32'(rsp_vld), 0);
    chk("R9 err low", 32'(rsp_err), 0);
    chk("R9 addr held", pci_addr, ha);
    chk("R9 map held", map_ctl, hm);
    chk("R9 host held", host_addr, hh);

    // R2: back-to-back requests, each with its own pulse
    @(negedge clk);
    req_vld = 1'b1; req_bus = VECS[1].bus; req_devfn = VECS[1].devfn; req_off = VECS[1].off;
    @(negedge clk);
    check_vec(VECS[1], "b2b first");
    req_bus = VECS[6].bus; req_devfn = VECS[6].devfn; req_off = VECS[6].off;
    @(negedge clk);
    req_vld = 1'b0;
    check_vec(VECS[6], "b2b second");
    @(negedge clk);
    chk("R2 single pulse", 32'(rsp_vld), 0);

    // R1: reset in operation clears everything
    rst_n = 1'b0;
    #1;
    chk("R1 mid addr", pci_addr, 0);
    chk("R1 mid map", map_ctl, 0);
    chk("R1 mid host", host_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(VECS[3]);
    check_vec(VECS[3], "after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule